// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial DAC Register Port

This block is the digital front end of a two-channel digital-to-analog converter. A host writes to it over a write-only SPI link made of a serial clock, a serial data line and an active-low chip select. Each write is a 16-bit word sent most significant bit first. Its upper four bits are control bits: a channel select, an unused bit, a gain select and a run bit that is low to shut the channel down. Its lower twelve bits are the conversion code. The block has no serial output and no readback path.

Every channel has two register stages. A complete frame is accepted when chip select rises, and it updates only the staging register of the channel it addresses. An active-low load strobe copies both staging registers into the live registers together, so both analog outputs can change at the same moment. The live registers drive DAC cores outside this block.

All four serial and strobe pins pass through two-flop synchronizers into the system clock domain, and edge detection runs there. Because the SPI data line is sampled only on rising SCK edges, SPI mode 0 (clock idles low) and mode 3 (clock idles high) both work. A parameter selects a reduced-resolution build that keeps only the upper bits of the code.

Top module: `dual_dac_port`

## Requirements
- R1: A frame is decoded as: bit 15 picks the channel (0 = A, 1 = B), bit 14 is ignored, bit 13 is the gain flag, bit 12 is the run flag (1 = running, 0 = shut down), and bits 11..0 are the code. Bit 15 is sent first.
- R2: SDI is sampled on rising SCK edges only. Frames sent with SCK idling low and frames sent with SCK idling high give the same result.
- R3: When chip select rises after a complete frame, the staging register of the addressed channel takes the decoded gain, run and code. The staging register of the other channel does not change.
- R4: If chip select rises after fewer than 16 rising SCK edges, the frame is discarded and no register changes.
- R5: Rising SCK edges after the 16th in one frame are ignored. The first 16 bits decide the result.
- R6: SCK and SDI activity while chip select is high has no effect on any register.
- R7: While the load strobe is high, the live outputs hold their value, even when staging registers are written.
- R8: When the load strobe goes low, both live registers take the staging contents in the same system clock cycle.
- R9: While the load strobe stays low, a committed frame reaches the live outputs without any further strobe edge.
- R10: When CODE_KEEP is less than 12, the low 12-CODE_KEEP bits of the stored code are zero and the upper bits match the frame.
- R11: After reset, both channels read code 0, gain 0 and run 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data, sampled on rising sck |
| cs_n | input | 1 | Active-low chip select; a rising edge commits the frame |
| ldac_n | input | 1 | Active-low load strobe, copies staging to live |
| code_a | output | 12 | Live code of channel A |
| code_b | output | 12 | Live code of channel B |
| gain_sel | output | 2 | Live gain flag per channel (bit 0 = A) |
| chan_on | output | 2 | Live run flag per channel, 1 = running (bit 0 = A) |

## Verification
The bench builds two instances side by side with SYNC_STAGES = 2. One has CODE_KEEP = 12 and the other has CODE_KEEP = 8, so each frame checks the full-code path and the truncated-code path in the same pass. A sweep of 64 frames covers every combination of channel, gain, run, SCK idle level and ignored bit 14, with spread-out codes and overlong frames. Separate passes drive short frames, clocks while chip select is high, the moment the strobe releases both channels, and the strobe held low.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int FRAME_W  = 16;
    localparam int CODE_W   = 12;
    localparam int NUM_CH   = 2;
    localparam int SEL_BIT  = 15;
    localparam int GAIN_BIT = 13;
    localparam int RUN_BIT  = 12;

    typedef struct packed {
        logic              gain;
        logic              run;
        logic [CODE_W-1:0] code;
    } chan_word_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dacif_rx.sv
module dacif_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               sdi_s,
    input  logic               cs_n_s,
    output logic               commit_o,
    output logic [FRAME_W-1:0] word_o
);
    localparam int              CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    typedef struct packed {
        logic               sck_prev;
        logic               cs_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic               commit;
        logic [FRAME_W-1:0] word;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      sck_rise, cs_rise;

    always_comb begin
        st_d          = st_q;
        st_d.commit   = 1'b0;
        st_d.sck_prev = sck_s;
        st_d.cs_prev  = cs_n_s;
        sck_rise      = sck_s & ~st_q.sck_prev;
        cs_rise       = cs_n_s & ~st_q.cs_prev;
        if (cs_n_s) begin
            st_d.cnt = '0;
            if (cs_rise && st_q.cnt == FULL) begin
                st_d.commit = 1'b1;
                st_d.word   = st_q.shreg;
            end
        end else if (sck_rise && st_q.cnt != FULL) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdi_s};
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sck_prev <= 1'b0;
            st_q.cs_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o = st_q.commit;
    assign word_o   = st_q.word;

    // R5
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    // R4
    commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.commit |-> $past(st_q.cnt) == FULL);

    // R6
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_s) |-> st_q.cnt == '0);
endmodule

// File: rtl/dacif_bank.sv
module dacif_bank
    import dacif_pkg::*;
#(
    parameter int NUM_CHAN  = 2,
    parameter int CODE_KEEP = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_i,
    input  logic [FRAME_W-1:0]          word_i,
    input  logic                        ldac_n_s,
    output chan_word_t [NUM_CHAN-1:0]   live_o
);
    localparam int SEL_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
    localparam int DROP_W   = CODE_W - CODE_KEEP;

    typedef struct packed {
        chan_word_t [NUM_CHAN-1:0] stage;
        chan_word_t [NUM_CHAN-1:0] live;
    } bank_state_t;

    bank_state_t       bk_d, bk_q;
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] code_in;
    chan_word_t        fresh;

    assign sel = word_i[SEL_BIT -: SEL_W];

    if (CODE_KEEP >= CODE_W) begin : g_full
        assign code_in = word_i[CODE_W-1:0];
    end else begin : g_trunc
        assign code_in = {word_i[CODE_W-1 -: CODE_KEEP], {DROP_W{1'b0}}};
    end

    always_comb begin
        fresh.gain = word_i[GAIN_BIT];
        fresh.run  = word_i[RUN_BIT];
        fresh.code = code_in;
    end

    always_comb begin
        bk_d = bk_q;
        if (commit_i) begin
            for (int ch = 0; ch < NUM_CHAN; ch++) begin
                if (sel == SEL_W'(ch)) bk_d.stage[ch] = fresh;
            end
        end
        if (!ldac_n_s) bk_d.live = bk_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign live_o = bk_q.live;

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chk
        // R7
        live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ldac_n_s) |-> $stable(bk_q.live[g]));

        // R3
        other_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_i && sel != SEL_W'(g)) |=> $stable(bk_q.stage[g]));

        if (CODE_KEEP < CODE_W) begin : g_low
            // R10
            low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bk_q.stage[g].code[DROP_W-1:0] == '0);
        end
    end
endmodule

// File: rtl/dual_dac_port.sv
module dual_dac_port
    import dacif_pkg::*;
#(
    parameter int CODE_KEEP   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              ldac_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic [1:0]        gain_sel,
    output logic [1:0]        chan_on
);
    logic [3:0]               pins_s;
    logic                     commit;
    logic [FRAME_W-1:0]       word;
    chan_word_t [NUM_CH-1:0]  live;

    dacif_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ldac_n, cs_n, sdi, sck}),
        .sync_o  (pins_s)
    );

    dacif_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (pins_s[0]),
        .sdi_s    (pins_s[1]),
        .cs_n_s   (pins_s[2]),
        .commit_o (commit),
        .word_o   (word)
    );

    dacif_bank #(.NUM_CHAN(NUM_CH), .CODE_KEEP(CODE_KEEP)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .ldac_n_s (pins_s[3]),
        .live_o   (live)
    );

    assign code_a   = live[0].code;
    assign code_b   = live[1].code;
    assign gain_sel = {live[1].gain, live[0].gain};
    assign chan_on  = {live[1].run, live[0].run};
endmodule

// File: tb/sim_dual_dac_port.sv
module sim_dual_dac_port;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, cs_n = 1'b1, ldac_n = 1'b1;
    logic [11:0] ca0, cb0, ca1, cb1;
    logic [1:0]  g0, r0, g1, r1;

    int n_cmp = 0;
    int n_bad = 0;

    logic [13:0] stage_m [2];
    logic [13:0] live_m  [2];

    always #10 clk = ~clk;

    dual_dac_port #(.CODE_KEEP(12), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n), .ldac_n(ldac_n),
        .code_a(ca0), .code_b(cb0), .gain_sel(g0), .chan_on(r0));

    dual_dac_port #(.CODE_KEEP(8), .SYNC_STAGES(2)) u1 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n), .ldac_n(ldac_n),
        .code_a(ca1), .code_b(cb1), .gain_sel(g1), .chan_on(r1));

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_live(input string tag);
        cmp({tag, " chA"}, {18'd0, g0[0], r0[0], ca0}, {18'd0, live_m[0]});
        cmp({tag, " chB"}, {18'd0, g0[1], r0[1], cb0}, {18'd0, live_m[1]});
        cmp({tag, " R10 chA low-res"}, {18'd0, g1[0], r1[0], ca1},
            {18'd0, live_m[0] & 14'h3FF0});
        cmp({tag, " R10 chB low-res"}, {18'd0, g1[1], r1[1], cb1},
            {18'd0, live_m[1] & 14'h3FF0});
    endtask

    task automatic send_frame(input logic [15:0] w, input int nclk, input bit idle_hi);
        sck = idle_hi;
        cycles(4);
        cs_n = 1'b0;
        cycles(4);
        for (int b = 0; b < nclk; b++) begin
            logic bitv;
            bitv = (b < 16) ? w[15-b] : ~w[b % 16];
            if (idle_hi) begin
                sck = 1'b0; sdi = bitv; cycles(HALF);
                sck = 1'b1; cycles(HALF);
            end else begin
                sdi = bitv; cycles(HALF);
                sck = 1'b1; cycles(HALF);
                sck = 1'b0;
            end
        end
        cycles(HALF);
        cs_n = 1'b1;
        cycles(8);
        if (nclk >= 16) stage_m[w[15]] = w[13:0];
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        cycles(4);
        ldac_n = 1'b1;
        cycles(6);
        live_m[0] = stage_m[0];
        live_m[1] = stage_m[1];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            stage_m[c] = '0;
            live_m[c]  = '0;
        end
        cycles(5);
        rst_n = 1'b1;
        cycles(5);
        // R11 reset state
        check_live("R11 reset");

        // R1 R2 R3 R5 R7 R8 R10 sweep over fields, idle level and overlong frames
        for (int i = 0; i < 64; i++) begin
            logic [15:0] w;
            w[15]    = i[0];
            w[13]    = i[1];
            w[12]    = i[2];
            w[14]    = i[4];
            w[11:0]  = 12'((i * 673 + 5) & 12'hFFF);
            send_frame(w, 16 + (i % 5), i[3]);
            check_live("R7 hold before strobe");
            pulse_ldac();
            check_live("R1 R2 R3 R5 decode");
        end

        // R4 short frames are discarded
        send_frame(16'h3ABC, 15, 1'b0);
        send_frame(16'hB123, 1, 1'b1);
        send_frame(16'h3FFF, 8, 1'b1);
        pulse_ldac();
        check_live("R4 short frame");

        // R6 activity with chip select high
        cs_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            sdi = k[0]; cycles(HALF);
            sck = 1'b1; cycles(HALF);
            sck = 1'b0;
        end
        send_frame(16'h2555, 15, 1'b0);
        pulse_ldac();
        check_live("R6 idle clocks");

        // R8 both channels change in one cycle
        send_frame(16'h3111, 16, 1'b0);
        send_frame(16'hB222, 16, 1'b1);
        begin
            logic [11:0] old_a, old_b;
            bit seen;
            old_a = ca0;
            old_b = cb0;
            seen = 1'b0;
            ldac_n = 1'b0;
            for (int k = 0; k < 10; k++) begin
                cycles(1);
                if (!seen && (ca0 != old_a || cb0 != old_b)) begin
                    seen = 1'b1;
                    cmp("R8 same-cycle A", {20'd0, ca0}, 32'h111);
                    cmp("R8 same-cycle B", {20'd0, cb0}, 32'h222);
                end
            end
            cmp("R8 change seen", {31'd0, seen}, 32'd1);
            ldac_n = 1'b1;
            cycles(4);
            live_m[0] = stage_m[0];
            live_m[1] = stage_m[1];
            check_live("R8 after strobe");
        end

        // R9 strobe held low passes writes through
        ldac_n = 1'b0;
        cycles(6);
        send_frame(16'h1ACE, 16, 1'b1);
        live_m[0] = stage_m[0];
        live_m[1] = stage_m[1];
        check_live("R9 held strobe A");
        send_frame(16'h9DEF, 17, 1'b0);
        live_m[0] = stage_m[0];
        live_m[1] = stage_m[1];
        check_live("R9 held strobe B");
        ldac_n = 1'b1;
        cycles(6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule